// File: doc/BRIEF.md
# Masked Status Condition Evaluator

This block decides, for the command a descriptor-driven transfer engine is running, whether to raise an interrupt, take a branch, and hold in a wait state. Each of the three decisions has its own programmable selector, a mask and a match value. The selector tests the 8-bit device-dependent status field: the masked status must equal the stored value. The match result is then qualified by a 2-bit policy code that the current command supplies.

Selector registers are loaded through a small synchronous write port that addresses one selector per write. The three decision outputs are combinational. They come from the registered selectors, the live status byte and the live policy codes, so the sequencer that owns the command can sample them in the same cycle it presents the codes.

Policy encoding: 0 means never, 1 means act when the condition holds, 2 means act when the condition fails, 3 means always. Selector index encoding on the write port: 0 selects interrupt, 1 selects branch, 2 selects wait, and 3 addresses nothing.

Top module: `status_cond_eval`

## Requirements
- R1: A selector's condition is true exactly when (dev_status AND mask) equals value. Value bits outside the mask therefore prevent a match; with an all-zero mask the condition is true only when the value is zero.
- R2: Policy code 0 forces the corresponding decision output low whatever the condition.
- R3: Policy code 3 forces the corresponding decision output high whatever the condition.
- R4: Policy code 1 drives the decision output equal to the selector's condition.
- R5: Policy code 2 drives the decision output equal to the inverse of the selector's condition.
- R6: The three selectors are independent. Interrupt uses index 0, branch uses index 1 and wait uses index 2. A write to one index leaves the other two selectors unchanged.
- R7: A write presented with cfg_we high is stored on the rising clock edge and affects the outputs only after that edge. Changes on dev_status and on the policy inputs affect the outputs in the same cycle.
- R8: After a synchronous active-low reset every mask and value is zero, so each condition is true.
- R9: A write with cfg_idx equal to 3 changes no selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Selector write strobe |
| cfg_idx | input | 2 | Selector index: 0 interrupt, 1 branch, 2 wait |
| cfg_mask | input | STAT_W | Mask to store |
| cfg_value | input | STAT_W | Match value to store |
| dev_status | input | STAT_W | Live device-dependent status field |
| irq_policy | input | 2 | Interrupt policy code |
| br_policy | input | 2 | Branch policy code |
| wait_policy | input | 2 | Wait policy code |
| irq_take | output | 1 | Raise interrupt |
| br_take | output | 1 | Take branch |
| wait_hold | output | 1 | Hold in wait |

## Verification
The bench builds the block with the default 8-bit status width, which is the field width the engine uses. At that width random mask, value and status bytes reach every bit position. Half of the random values are drawn from inside the mask, so that matches and mismatches both occur often. The index range includes the unused code 3, which exercises the ignored-write path.

// File: rtl/status_cond_pkg.sv
// Package: shared types and constants for the masked status condition evaluator.
// Assumes three selectors whose indices are fixed by the engine's command decoding.
package status_cond_pkg;
    localparam int NUM_SEL   = 3;
    localparam int SEL_IDX_W = 2;
    localparam int IDX_IRQ   = 0;
    localparam int IDX_BR    = 1;
    localparam int IDX_WAIT  = 2;

    typedef enum logic [1:0] {
        POL_NEVER    = 2'd0,
        POL_IF_TRUE  = 2'd1,
        POL_IF_FALSE = 2'd2,
        POL_ALWAYS   = 2'd3
    } policy_e;
endpackage

// File: rtl/sel_reg.sv
// sel_reg: holds one mask/value selector pair.
// It loads both fields on a write addressed to its own index and keeps them otherwise.
// Assumes a synchronous active-low reset; the reset state is all zeros.
module sel_reg #(
    parameter int STAT_W = 8,
    parameter int IDX_W  = 2,
    parameter int MY_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [STAT_W-1:0] mask_in,
    input  logic [STAT_W-1:0] value_in,
    output logic [STAT_W-1:0] mask_q,
    output logic [STAT_W-1:0] value_q
);
    localparam logic [IDX_W-1:0] HIT_IDX = IDX_W'(MY_IDX);

    logic hit;
    assign hit = we && (idx == HIT_IDX);

    // Purpose: store the selector fields on an addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            value_q <= '0;
        end else if (hit) begin
            mask_q  <= mask_in;
            value_q <= value_in;
        end
    end

    // R7: an addressed write lands on the next edge
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == HIT_IDX) |=> (mask_q == $past(mask_in) && value_q == $past(value_in)));

    // R6, R9: any other write, or no write, leaves the fields alone
    p_hold_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && idx == HIT_IDX) |=> ($stable(mask_q) && $stable(value_q)));
endmodule

// File: rtl/sel_match.sv
// sel_match: tests the status field against one selector.
// The result is true when the masked status equals the stored value.
// Assumes value bits outside the mask are not cleared, so they block a match.
module sel_match #(
    parameter int STAT_W = 8
) (
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] mask,
    input  logic [STAT_W-1:0] value,
    output logic              cond
);
    // Purpose: compare the masked status with the value.
    always_comb begin
        cond = ((status & mask) == value);
    end
endmodule

// File: rtl/sel_policy.sv
// sel_policy: qualifies one condition with a four-way policy code.
// Assumes the code is stable for as long as the command that supplies it is current.
module sel_policy
    import status_cond_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  policy_e policy,
    input  logic    cond,
    output logic    take
);
    // Purpose: map the policy and the condition to the decision.
    always_comb begin
        unique case (policy)
            POL_NEVER:    take = 1'b0;
            POL_IF_TRUE:  take = cond;
            POL_IF_FALSE: take = !cond;
            POL_ALWAYS:   take = 1'b1;
            default:      take = 1'b0;
        endcase
    end

    // R2: never means never
    p_never_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_NEVER) |-> !take);

    // R3: always means always
    p_always_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_ALWAYS) |-> take);

    // R4, R5: the conditional codes follow the condition in opposite senses
    p_cond_sense_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_IF_TRUE || policy == POL_IF_FALSE)
            |-> (take == (cond ^ (policy == POL_IF_FALSE))));
endmodule

// File: rtl/status_cond_eval.sv
// status_cond_eval: three mask/value selectors (interrupt, branch, wait).
// Each is matched against the device status field and qualified by a policy code.
// Assumes the status field and the policy codes come from the running command and are live.
module status_cond_eval
    import status_cond_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_IDX_W-1:0] cfg_idx,
    input  logic [STAT_W-1:0]    cfg_mask,
    input  logic [STAT_W-1:0]    cfg_value,
    input  logic [STAT_W-1:0]    dev_status,
    input  logic [1:0]           irq_policy,
    input  logic [1:0]           br_policy,
    input  logic [1:0]           wait_policy,
    output logic                 irq_take,
    output logic                 br_take,
    output logic                 wait_hold
);
    logic [STAT_W-1:0] mask_arr  [NUM_SEL];
    logic [STAT_W-1:0] value_arr [NUM_SEL];
    logic [1:0]        pol_arr   [NUM_SEL];
    logic              cond_arr  [NUM_SEL];
    logic              take_arr  [NUM_SEL];

    // Purpose: gather the per-selector policy codes in index order.
    always_comb begin
        pol_arr[IDX_IRQ]  = irq_policy;
        pol_arr[IDX_BR]   = br_policy;
        pol_arr[IDX_WAIT] = wait_policy;
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        sel_reg #(
            .STAT_W (STAT_W),
            .IDX_W  (SEL_IDX_W),
            .MY_IDX (g)
        ) i_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (cfg_we),
            .idx      (cfg_idx),
            .mask_in  (cfg_mask),
            .value_in (cfg_value),
            .mask_q   (mask_arr[g]),
            .value_q  (value_arr[g])
        );

        sel_match #(
            .STAT_W (STAT_W)
        ) i_match (
            .status (dev_status),
            .mask   (mask_arr[g]),
            .value  (value_arr[g]),
            .cond   (cond_arr[g])
        );

        sel_policy i_pol (
            .clk    (clk),
            .rst_n  (rst_n),
            .policy (policy_e'(pol_arr[g])),
            .cond   (cond_arr[g]),
            .take   (take_arr[g])
        );
    end

    // Purpose: route the qualified decisions to the named outputs.
    always_comb begin
        irq_take  = take_arr[IDX_IRQ];
        br_take   = take_arr[IDX_BR];
        wait_hold = take_arr[IDX_WAIT];
    end
endmodule

// File: tb/test_status_cond_eval.sv
`timescale 1ns/1ps
module test_status_cond_eval;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_idx = '0;
    logic [W-1:0] cfg_mask = '0;
    logic [W-1:0] cfg_value = '0;
    logic [W-1:0] dev_status = '0;
    logic [1:0]   irq_policy = '0;
    logic [1:0]   br_policy = '0;
    logic [1:0]   wait_policy = '0;
    logic         irq_take, br_take, wait_hold;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] m_mask [3];
    logic [W-1:0] m_val  [3];

    always #2.5 clk = ~clk;

    status_cond_eval #(.STAT_W(W)) i_status_cond_eval (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_mask(cfg_mask), .cfg_value(cfg_value), .dev_status(dev_status),
        .irq_policy(irq_policy), .br_policy(br_policy), .wait_policy(wait_policy),
        .irq_take(irq_take), .br_take(br_take), .wait_hold(wait_hold)
    );

    function automatic logic ref_take(input logic [1:0] pol, input logic [W-1:0] st,
                                      input logic [W-1:0] mk, input logic [W-1:0] vl);
        logic c;
        c = ((st & mk) == vl);
        case (pol)
            2'd0: return 1'b0;
            2'd1: return c;
            2'd2: return !c;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        #0.5;
        check_bit({req, " irq"},  irq_take,  ref_take(irq_policy,  dev_status, m_mask[0], m_val[0]));
        check_bit({req, " br"},   br_take,   ref_take(br_policy,   dev_status, m_mask[1], m_val[1]));
        check_bit({req, " wait"}, wait_hold, ref_take(wait_policy, dev_status, m_mask[2], m_val[2]));
    endtask

    // drive a write at a negedge; the model follows after the edge
    task automatic do_write(input logic [1:0] idx, input logic [W-1:0] mk, input logic [W-1:0] vl);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_mask = mk; cfg_value = vl;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (idx != 2'd3) begin
            m_mask[idx] = mk;
            m_val[idx]  = vl;
        end
    endtask

    initial begin : watchdog
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        for (int i = 0; i < 3; i++) begin m_mask[i] = '0; m_val[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: after reset every condition is true, so code 1 fires and code 2 does not
        @(negedge clk);
        dev_status = 8'hA7; irq_policy = 2'd1; br_policy = 2'd1; wait_policy = 2'd2;
        #0.5;
        check_bit("R8 irq",  irq_take,  1'b1);
        check_bit("R8 br",   br_take,   1'b1);
        check_bit("R8 wait", wait_hold, 1'b0);

        // R9: index 3 writes go nowhere; the conditions stay true
        do_write(2'd3, 8'hFF, 8'h55);
        @(negedge clk);
        dev_status = 8'h00; irq_policy = 2'd1; br_policy = 2'd1; wait_policy = 2'd1;
        #0.5;
        check_bit("R9 irq",  irq_take,  1'b1);
        check_bit("R9 br",   br_take,   1'b1);
        check_bit("R9 wait", wait_hold, 1'b1);

        // R1: value bit outside the mask blocks the match
        do_write(2'd0, 8'h0F, 8'h13);
        @(negedge clk);
        dev_status = 8'hF3; irq_policy = 2'd1;
        #0.5;
        check_bit("R1 outside-mask value", irq_take, 1'b0);
        // R1: zero mask with zero value is true; with a nonzero value it is false
        do_write(2'd1, 8'h00, 8'h00);
        do_write(2'd2, 8'h00, 8'h01);
        @(negedge clk);
        dev_status = 8'h5A; br_policy = 2'd1; wait_policy = 2'd1;
        #0.5;
        check_bit("R1 zero mask zero value", br_take, 1'b1);
        check_bit("R1 zero mask nonzero value", wait_hold, 1'b0);

        // R7: the write is not visible before the edge, and visible after it
        @(negedge clk);
        do_write(2'd0, 8'h0F, 8'h03); // irq now matches 0xF3
        @(negedge clk);
        irq_policy = 2'd1; dev_status = 8'hF3;
        #0.5;
        check_bit("R7 after edge", irq_take, 1'b1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'd0; cfg_mask = 8'hFF; cfg_value = 8'h00;
        #0.5;
        check_bit("R7 before edge", irq_take, 1'b1);
        @(posedge clk); #1 cfg_we = 1'b0;
        m_mask[0] = 8'hFF; m_val[0] = 8'h00;
        #0.5;
        check_bit("R7 landed", irq_take, 1'b0);
        // R7: status change alone flips the result in the same cycle
        dev_status = 8'h00;
        #0.5;
        check_bit("R7 live status", irq_take, 1'b1);
        // R6: the earlier branch and wait selectors are unchanged
        check_bit("R6 br kept",   br_take,   1'b1);
        check_bit("R6 wait kept", wait_hold, 1'b0);

        // R2 R3 R4 R5: every policy on every selector against random selectors
        for (int n = 0; n < 400; n++) begin
            logic [1:0]   ix;
            logic [W-1:0] mk, vl;
            ix = 2'($urandom_range(0, 3));
            mk = 8'($urandom);
            vl = ($urandom_range(0, 1) == 1) ? (8'($urandom) & mk) : 8'($urandom);
            do_write(ix, mk, vl);
            for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                dev_status  = ($urandom_range(0, 1) == 1) ? (m_val[p % 3] | (8'($urandom) & ~m_mask[p % 3])) : 8'($urandom);
                irq_policy  = 2'(p);
                br_policy   = 2'((p + 1) % 4);
                wait_policy = 2'((p + 2) % 4);
                case (p)
                    0: check_all("R2/R4 policy mix");
                    1: check_all("R4/R5 policy mix");
                    2: check_all("R5/R3 policy mix");
                    default: check_all("R3/R2 policy mix");
                endcase
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule